// File: doc/BRIEF.md
# UART Interrupt Source Resolver

This block collects every interrupt cause of a 16550-style serial port, picks the most urgent one under a fixed ranking, and presents it as an 8-bit identification byte plus one interrupt request line. The line-status error bits, the data-ready flag, the receive FIFO fill count and its trigger level, the character-timeout flag and the modem-status change bits all come in as status signals from neighbouring logic. The block does not hold the FIFOs, shifters or baud logic.

The block owns two pieces of state. The first is the interrupt-enable register, in which only the four low bits are kept. The second is the "holding register empty" pending flag. The host strobes affect this flag: a holding-register write, a read of the identification byte, an enable-register write and a transmit-FIFO reset. The transmitter raises the flag again when it drains the holding register. The identification byte and the request line are registered, so they follow the source state by one clock.

Top module: `uart_irq_ident`

## Requirements
- R1: When several enabled sources are active, the reported source follows this ranking, highest first: line error (any of `lineErr[3:0]` set, enabled by IER bit 2), character timeout (IER bit 0), received data (IER bit 0), holding register empty (pending flag, IER bit 1), modem change (any of `msrDelta[3:0]`, IER bit 3).
- R2: `iirQ[3:0]` is 0x1 with nothing pending, 0x6 for line error, 0xC for character timeout, 0x4 for received data, 0x2 for holding register empty and 0x0 for modem change.
- R3: `iirQ[7:6]` is 2'b11 while `fifoEn` is high and 2'b00 otherwise, independent of the low nibble; `iirQ[5:4]` is always zero.
- R4: The character-timeout source is ignored unless IER bit 0 is set.
- R5: With `fifoEn` high, received data is reported only when `dataReady` is set and `rxCount >= rxTrigLevel`; with `fifoEn` low, `dataReady` alone is enough.
- R6: A pulse on `iirRd` clears the pending flag when `iirQ[3:0]` is 0x2 in that cycle, and leaves it unchanged otherwise.
- R7: An IER write that changes bit 1 from 0 to 1 while `thrEmpty` is high sets the pending flag; the same change while `thrEmpty` is low does not; an IER write that changes bit 1 from 1 to 0 clears it.
- R8: A `thrWr` pulse clears the pending flag; a `txFifoRst` or `holdDrained` pulse sets it.
- R9: Only IER bits 3:0 are stored; `ierQ[7:4]` always reads zero.
- R10: `irqOut` is registered, changes on the same clock edge as `iirQ`, and is high exactly when `iirQ[3:0]` is not 0x1.
- R11: When a set event and a clear event for the pending flag fall in the same cycle, the flag ends up set.
- R12: After reset, `iirQ` is 0x01, `irqOut` is low, `ierQ` is zero and the pending flag is clear.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ierWrEn | input | 1 | Write strobe for the enable register |
| ierWrData | input | 8 | Data for the enable register write |
| ierQ | output | 8 | Enable register contents, upper nibble zero |
| fifoEn | input | 1 | FIFO mode active |
| lineErr | input | 4 | Break, framing, parity and overrun status bits |
| dataReady | input | 1 | Receive data present |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxTrigLevel | input | CNT_W | Receive FIFO trigger level |
| timeoutPend | input | 1 | Character timeout has expired |
| msrDelta | input | 4 | Modem status change bits |
| thrEmpty | input | 1 | Holding register currently empty |
| holdDrained | input | 1 | Pulse: transmitter has just emptied the holding register |
| thrWr | input | 1 | Pulse: host wrote the holding register |
| iirRd | input | 1 | Pulse: host read the identification byte |
| txFifoRst | input | 1 | Pulse: transmit FIFO reset |
| threPendQ | output | 1 | Holding-register-empty pending flag |
| iirQ | output | 8 | Interrupt identification byte |
| irqOut | output | 1 | Interrupt request |

## Verification
The pending flag can receive a set and a clear in the same cycle. This happens when the host reads the identification byte while it shows 0x2, or writes the holding register, in the same cycle as the transmitter drains the holding register or the transmit FIFO is reset. The bench drives both pulses on the same clock edge and then reads the flag and the identification byte at the ports. It expects the flag to stay set and the code to stay 0x2. A checker property also requires the flag to be set one cycle after any set pulse, whatever clear arrives with it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // strobes from control to datapath for the holding-empty pending flag
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } threStrb_t;

  localparam int NUM_SRC = 5;

  localparam logic [3:0] CODE_NONE  = 4'h1;
  localparam logic [3:0] CODE_LINE  = 4'h6;
  localparam logic [3:0] CODE_TMO   = 4'hC;
  localparam logic [3:0] CODE_RDA   = 4'h4;
  localparam logic [3:0] CODE_THRE  = 4'h2;
  localparam logic [3:0] CODE_MODEM = 4'h0;

  // source index 0 is the most urgent
  function automatic logic [3:0] srcCode(input int idx);
    case (idx)
      0:       srcCode = CODE_LINE;
      1:       srcCode = CODE_TMO;
      2:       srcCode = CODE_RDA;
      3:       srcCode = CODE_THRE;
      default: srcCode = CODE_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ierWrEn,
  input  logic [7:0] ierWrData,
  input  logic       thrEmpty,
  input  logic       holdDrained,
  input  logic       thrWr,
  input  logic       iirRd,
  input  logic       txFifoRst,
  input  logic [3:0] iirCodeQ,
  output logic [3:0] ierMask,
  output threStrb_t  threStrb
);

  localparam int IER_BITS = 4;

  logic [IER_BITS-1:0] ierReg;
  logic ierRise1;
  logic ierFall1;
  logic readHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ierReg <= '0;
    else if (ierWrEn) ierReg <= ierWrData[IER_BITS-1:0];
  end

  always_comb begin
    ierRise1 = ierWrEn && ierWrData[1] && !ierReg[1];
    ierFall1 = ierWrEn && !ierWrData[1] && ierReg[1];
    readHit  = iirRd && (iirCodeQ == CODE_THRE);
    threStrb.setPend = holdDrained || txFifoRst || (ierRise1 && thrEmpty);
    threStrb.clrPend = thrWr || readHit || ierFall1;
  end

  assign ierMask = ierReg;

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ierMask,
  input  threStrb_t        threStrb,
  input  logic             fifoEn,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic             timeoutPend,
  input  logic [3:0]       msrDelta,
  output logic             threPendQ,
  output logic [7:0]       iirQ,
  output logic             irqOut
);

  logic [NUM_SRC-1:0] srcHit;
  logic [3:0]         codeNext;
  logic               rdaOk;

  // pending flag: set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) threPendQ <= 1'b0;
    else if (threStrb.setPend) threPendQ <= 1'b1;
    else if (threStrb.clrPend) threPendQ <= 1'b0;
  end

  always_comb begin
    rdaOk     = dataReady && (!fifoEn || (rxCount >= rxTrigLevel));
    srcHit[0] = ierMask[2] && (|lineErr);
    srcHit[1] = ierMask[0] && timeoutPend;
    srcHit[2] = ierMask[0] && rdaOk;
    srcHit[3] = ierMask[1] && threPendQ;
    srcHit[4] = ierMask[3] && (|msrDelta);
  end

  // walk from lowest rank upward so the highest hit wins
  always_comb begin
    codeNext = CODE_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcHit[i]) codeNext = srcCode(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iirQ   <= {4'h0, CODE_NONE};
      irqOut <= 1'b0;
    end else begin
      iirQ   <= {{2{fifoEn}}, 2'b00, codeNext};
      irqOut <= (codeNext != CODE_NONE);
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ierWrEn,
  input  logic [7:0]       ierWrData,
  output logic [7:0]       ierQ,
  input  logic             fifoEn,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic             timeoutPend,
  input  logic [3:0]       msrDelta,
  input  logic             thrEmpty,
  input  logic             holdDrained,
  input  logic             thrWr,
  input  logic             iirRd,
  input  logic             txFifoRst,
  output logic             threPendQ,
  output logic [7:0]       iirQ,
  output logic             irqOut
);

  logic [3:0] ierMask;
  threStrb_t  threStrb;

  uart_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ierWrEn    (ierWrEn),
    .ierWrData  (ierWrData),
    .thrEmpty   (thrEmpty),
    .holdDrained(holdDrained),
    .thrWr      (thrWr),
    .iirRd      (iirRd),
    .txFifoRst  (txFifoRst),
    .iirCodeQ   (iirQ[3:0]),
    .ierMask    (ierMask),
    .threStrb   (threStrb)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ierMask    (ierMask),
    .threStrb   (threStrb),
    .fifoEn     (fifoEn),
    .lineErr    (lineErr),
    .dataReady  (dataReady),
    .rxCount    (rxCount),
    .rxTrigLevel(rxTrigLevel),
    .timeoutPend(timeoutPend),
    .msrDelta   (msrDelta),
    .threPendQ  (threPendQ),
    .iirQ       (iirQ),
    .irqOut     (irqOut)
  );

  assign ierQ = {4'h0, ierMask};

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ierWrEn,
  input logic [7:0] ierWrData,
  input logic [7:0] ierQ,
  input logic [3:0] lineErr,
  input logic       thrEmpty,
  input logic       holdDrained,
  input logic       thrWr,
  input logic       iirRd,
  input logic       txFifoRst,
  input logic       threPendQ,
  input logic [7:0] iirQ,
  input logic       irqOut
);

  logic anySet;
  assign anySet = holdDrained || txFifoRst ||
                  (ierWrEn && ierWrData[1] && !ierQ[1] && thrEmpty);

  // R10: request line agrees with the reported code
  a_r10_irq_matches_code: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (iirQ[3:0] != 4'h1));

  // R3: reserved bits of the identification byte stay zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    iirQ[5:4] == 2'b00);

  // R9: enable register upper nibble reads zero
  a_r9_ier_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    ierQ[7:4] == 4'h0);

  // R2: only legal codes appear
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    iirQ[3:0] inside {4'h1, 4'h6, 4'hC, 4'h4, 4'h2, 4'h0});

  // R1: an enabled line error always ranks first
  a_r1_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (ierQ[2] && (|lineErr)) |=> iirQ[3:0] == 4'h6);

  // R11: any set event leaves the flag set
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    anySet |=> threPendQ);

  // R8: holding write without a set event clears the flag
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (thrWr && !anySet) |=> !threPendQ);

  // R6: reading a THRE code without a set event clears the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (iirRd && iirQ[3:0] == 4'h2 && !anySet) |=> !threPendQ);

  // R7: disabling the THRE source clears the flag
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ierWrEn && ierQ[1] && !ierWrData[1] && !anySet) |=> !threPendQ);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ierWrEn    (ierWrEn),
  .ierWrData  (ierWrData),
  .ierQ       (ierQ),
  .lineErr    (lineErr),
  .thrEmpty   (thrEmpty),
  .holdDrained(holdDrained),
  .thrWr      (thrWr),
  .iirRd      (iirRd),
  .txFifoRst  (txFifoRst),
  .threPendQ  (threPendQ),
  .iirQ       (iirQ),
  .irqOut     (irqOut)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ierWrEn = 1'b0;
  logic [7:0] ierWrData = '0;
  logic [7:0] ierQ;
  logic fifoEn = 1'b0;
  logic [3:0] lineErr = '0;
  logic dataReady = 1'b0;
  logic [CNT_W-1:0] rxCount = '0;
  logic [CNT_W-1:0] rxTrigLevel = 5'd1;
  logic timeoutPend = 1'b0;
  logic [3:0] msrDelta = '0;
  logic thrEmpty = 1'b0;
  logic holdDrained = 1'b0;
  logic thrWr = 1'b0;
  logic iirRd = 1'b0;
  logic txFifoRst = 1'b0;
  logic threPendQ;
  logic [7:0] iirQ;
  logic irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .ierWrData(ierWrData), .ierQ(ierQ),
    .fifoEn(fifoEn), .lineErr(lineErr), .dataReady(dataReady), .rxCount(rxCount),
    .rxTrigLevel(rxTrigLevel), .timeoutPend(timeoutPend), .msrDelta(msrDelta),
    .thrEmpty(thrEmpty), .holdDrained(holdDrained), .thrWr(thrWr), .iirRd(iirRd),
    .txFifoRst(txFifoRst), .threPendQ(threPendQ), .iirQ(iirQ), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic writeIer(input logic [7:0] val);
    @(negedge clk);
    ierWrEn = 1'b1; ierWrData = val;
    @(negedge clk);
    ierWrEn = 1'b0;
    settle();
  endtask

  task automatic clearAll();
    lineErr = '0; dataReady = 1'b0; timeoutPend = 1'b0; msrDelta = '0;
    fifoEn = 1'b0; rxCount = '0; rxTrigLevel = 5'd1; thrEmpty = 1'b0;
    writeIer(8'h00);
    @(negedge clk); thrWr = 1'b1;
    @(negedge clk); thrWr = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    check("R12 iir after reset", iirQ, 8'h01);
    check("R12 irq after reset", {7'd0, irqOut}, 8'h00);
    check("R12 ier after reset", ierQ, 8'h00);
    check("R12 pending after reset", {7'd0, threPendQ}, 8'h00);
  endtask

  task automatic t_ier_upper();
    writeIer(8'hFF);
    check("R9 ier upper bits", ierQ, 8'h0F);
    check("R7 rise without empty", {7'd0, threPendQ}, 8'h00);
    writeIer(8'h00);
  endtask

  task automatic t_priority();
    writeIer(8'h0D);
    lineErr = 4'b0100; timeoutPend = 1'b1; dataReady = 1'b1; msrDelta = 4'b0001;
    settle();
    check("R1 line error wins", iirQ, 8'h06);
    lineErr = '0; settle();
    check("R1 timeout next", iirQ, 8'h0C);
    timeoutPend = 1'b0; settle();
    check("R1 received data next", iirQ, 8'h04);
    // enable THRE with holding empty: pending arms, still below data
    thrEmpty = 1'b1;
    writeIer(8'h0F);
    check("R1 data above THRE", iirQ, 8'h04);
    dataReady = 1'b0; settle();
    check("R2 THRE code above modem", iirQ, 8'h02);
    @(negedge clk); thrWr = 1'b1;
    @(negedge clk); thrWr = 1'b0;
    settle();
    check("R2 modem code", iirQ, 8'h00);
    check("R10 irq for modem code 0", {7'd0, irqOut}, 8'h01);
    msrDelta = '0; settle();
    check("R2 none code", iirQ, 8'h01);
    check("R10 irq low when none", {7'd0, irqOut}, 8'h00);
    clearAll();
  endtask

  task automatic t_fifo_bits();
    writeIer(8'h04);
    fifoEn = 1'b1; lineErr = 4'b0001; settle();
    check("R3 fifo bits with code", iirQ, 8'hC6);
    lineErr = '0; settle();
    check("R3 fifo bits without code", iirQ, 8'hC1);
    fifoEn = 1'b0; settle();
    check("R3 fifo bits clear", iirQ, 8'h01);
    clearAll();
  endtask

  task automatic t_timeout_gate();
    writeIer(8'h0C);
    timeoutPend = 1'b1; settle();
    check("R4 timeout masked", iirQ, 8'h01);
    writeIer(8'h01);
    check("R4 timeout enabled", iirQ, 8'h0C);
    clearAll();
  endtask

  task automatic t_trigger();
    writeIer(8'h01);
    fifoEn = 1'b1; rxTrigLevel = 5'd4; rxCount = 5'd3; dataReady = 1'b1; settle();
    check("R5 below trigger", iirQ, 8'hC1);
    rxCount = 5'd4; settle();
    check("R5 at trigger", iirQ, 8'hC4);
    fifoEn = 1'b0; rxCount = 5'd0; settle();
    check("R5 non-fifo data ready", iirQ, 8'h04);
    clearAll();
  endtask

  task automatic t_irq_latency();
    writeIer(8'h01);
    @(negedge clk); dataReady = 1'b1;
    #1;
    check("R10 irq not yet", {7'd0, irqOut}, 8'h00);
    @(negedge clk);
    check("R10 irq after one edge", {7'd0, irqOut}, 8'h01);
    check("R10 code same edge", iirQ, 8'h04);
    clearAll();
  endtask

  task automatic t_read_clear();
    writeIer(8'h03);
    @(negedge clk); txFifoRst = 1'b1;
    @(negedge clk); txFifoRst = 1'b0;
    settle();
    check("R8 fifo reset sets pending", {7'd0, threPendQ}, 8'h01);
    check("R6 THRE reported", iirQ, 8'h02);
    @(negedge clk); iirRd = 1'b1;
    @(negedge clk); iirRd = 1'b0;
    settle();
    check("R6 read clears pending", {7'd0, threPendQ}, 8'h00);
    check("R6 code after read", iirQ, 8'h01);
    // read while a higher code is shown keeps pending
    @(negedge clk); holdDrained = 1'b1;
    @(negedge clk); holdDrained = 1'b0;
    check("R8 drained sets pending", {7'd0, threPendQ}, 8'h01);
    dataReady = 1'b1; settle();
    @(negedge clk); iirRd = 1'b1;
    @(negedge clk); iirRd = 1'b0;
    settle();
    check("R6 other code read keeps pending", {7'd0, threPendQ}, 8'h01);
    dataReady = 1'b0; settle();
    check("R6 THRE back", iirQ, 8'h02);
    @(negedge clk); thrWr = 1'b1;
    @(negedge clk); thrWr = 1'b0;
    settle();
    check("R8 write clears pending", {7'd0, threPendQ}, 8'h00);
    clearAll();
  endtask

  task automatic t_ier_toggle();
    thrEmpty = 1'b1;
    writeIer(8'h02);
    check("R7 rise with empty sets", {7'd0, threPendQ}, 8'h01);
    writeIer(8'h02);
    check("R7 rewrite keeps", {7'd0, threPendQ}, 8'h01);
    writeIer(8'h00);
    check("R7 disable clears", {7'd0, threPendQ}, 8'h00);
    thrEmpty = 1'b0;
    writeIer(8'h02);
    check("R7 rise while full", {7'd0, threPendQ}, 8'h00);
    clearAll();
  endtask

  task automatic t_collide();
    writeIer(8'h02);
    @(negedge clk); holdDrained = 1'b1;
    @(negedge clk); holdDrained = 1'b0;
    settle();
    check("R11 setup code", iirQ, 8'h02);
    @(negedge clk); iirRd = 1'b1; holdDrained = 1'b1;
    @(negedge clk); iirRd = 1'b0; holdDrained = 1'b0;
    settle();
    check("R11 read vs drain pending", {7'd0, threPendQ}, 8'h01);
    check("R11 read vs drain code", iirQ, 8'h02);
    @(negedge clk); thrWr = 1'b1; txFifoRst = 1'b1;
    @(negedge clk); thrWr = 1'b0; txFifoRst = 1'b0;
    settle();
    check("R11 write vs fifo reset", {7'd0, threPendQ}, 8'h01);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    settle();
    t_reset();
    t_ier_upper();
    t_priority();
    t_fifo_bits();
    t_timeout_gate();
    t_trigger();
    t_irq_latency();
    t_read_clear();
    t_ier_toggle();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule